// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block sits between a 20-bit, byte-addressed processor bus and a bank of memory devices of equal size. It splits each bus address into two parts. The upper part is a slot number that picks one device. The lower part is the local address, which goes to every device unchanged. The read and write strobes are active-low. One registered, active-low chip enable is produced per device, and the strobes are passed on only when a device has been hit. When a bus cycle finds no device, an `unmapped` flag is raised so that a bus monitor can report the access.

A parameter picks one of two decoding schemes. With full decoding, every slot bit is compared, and the devices occupy a contiguous window of slots that starts at `BASE_SLOT`. Slots outside that window are holes. With partial decoding, only the lowest log2(`NUM_DEV`) slot bits are compared. Images of the bank then repeat across the whole map. For example, a single 512 KB device answers both at A0023h and at 20023h. Device size, device count and base slot are all parameters, so the same block can serve two 512 KB parts, four 256 KB parts or 128 parts of 8 KB. Every output is registered, which gives one cycle of latency.

Top module: `memmap_cs_decoder`

## Requirements
- R1: While `rst_n` is low, every `cs_n` bit, `rd_dev_n` and `wr_dev_n` are 1, `local_addr` is 0 and `unmapped` is 0.
- R2: With full decoding (`FULL_DECODE`=1), during a single-strobe cycle, `cs_n[i]` is 0 exactly when slot = `bus_addr[ADDR_W-1:DEV_AW]` equals `BASE_SLOT`+i.
- R3: With full decoding, a single-strobe cycle whose slot lies outside `BASE_SLOT`..`BASE_SLOT`+`NUM_DEV`-1 leaves all `cs_n` at 1 and sets `unmapped` to 1. `unmapped` is never 1 while any `cs_n` bit is 0.
- R4: With partial decoding (`FULL_DECODE`=0), only the low log2(`NUM_DEV`) slot bits are compared. Device i answers wherever those bits equal the same bits of `BASE_SLOT`+i. A single-strobe cycle always hits one device, so `unmapped` stays 0.
- R5: At most one `cs_n` bit is 0 in any cycle.
- R6: With both strobes high (idle), all `cs_n`, `rd_dev_n` and `wr_dev_n` are 1 and `unmapped` is 0.
- R7: With both strobes low (a clash), no `cs_n` bit is 0, both gated strobes stay 1 and `unmapped` stays 0.
- R8: `local_addr` equals `bus_addr[DEV_AW-1:0]` as sampled at the previous clock edge, whatever the strobes are.
- R9: `rd_dev_n` is 0 only for a read cycle (`rd_n`=0, `wr_n`=1) that hits a device. `wr_dev_n` is 0 only for a write cycle (`rd_n`=1, `wr_n`=0) that hits a device.
- R10: All outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R11: With `DEV_AW`=13 and `NUM_DEV`=128 in full decoding at base 0, the seven bits `bus_addr[19:13]` give the index of the enabled device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address from the processor bus |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_n | output | NUM_DEV | One active-low chip enable per device |
| rd_dev_n | output | 1 | Read strobe to the devices, gated by a hit |
| wr_dev_n | output | 1 | Write strobe to the devices, gated by a hit |
| local_addr | output | DEV_AW | Low address bits that every device sees |
| unmapped | output | 1 | A single-strobe cycle that hit no device |

## Verification
The bench targets the window edges of full decoding: the last byte below the base (7FFFFh), the first byte of the window (80000h), the last byte of the window (FFFFFh), and the boundary between the two devices. An off-by-one slot compare would enable a device in a hole, or would leave the top image unanswered with `unmapped` raised. In partial mode, A0023h and 20023h must reach the same device at the same local address. A decoder that kept the high bit would drop one of these two images. The bench also drives idle cycles and clash cycles. A decoder that gated the enables on only one strobe would fire a device, or raise `unmapped`, when no legal cycle was present.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   // Bus cycle kind, derived from the two active-low strobes
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_CLASH = 2'd3
   } cs_access_e;

   function automatic logic acc_is_single(input cs_access_e a);
      return (a == ACC_READ) || (a == ACC_WRITE);
   endfunction

endpackage

// File: rtl/cs_slot_match.sv
module cs_slot_match #(
   parameter int SEL_W       = 2,
   parameter int NUM_DEV     = 2,
   parameter int BASE_SLOT   = 2,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic [SEL_W-1:0]   slot_i,
   output logic [NUM_DEV-1:0] hit_o
);

   localparam int DEC_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 0;

   for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_dev
      if (FULL_DECODE) begin : g_full
         localparam logic [SEL_W-1:0] MY_SLOT = SEL_W'(BASE_SLOT + gi);
         assign hit_o[gi] = (slot_i == MY_SLOT);
      end else if (DEC_W == 0) begin : g_part_single
         // A lone device answers in every slot
         logic unused_slot;
         assign unused_slot = ^slot_i;
         assign hit_o[gi]   = 1'b1;
      end else begin : g_part
         localparam int          MY_FULL = BASE_SLOT + gi;
         localparam logic [DEC_W-1:0] MY_LOW = DEC_W'(MY_FULL);
         logic unused_slot;
         assign unused_slot = ^slot_i;
         assign hit_o[gi]   = (slot_i[DEC_W-1:0] == MY_LOW);
      end
   end

endmodule

// File: rtl/cs_access_qual.sv
module cs_access_qual
   import cs_dec_pkg::*;
(
   input  logic       rd_n_i,
   input  logic       wr_n_i,
   output cs_access_e acc_o
);

   always_comb begin
      unique case ({rd_n_i, wr_n_i})
         2'b11:   acc_o = ACC_IDLE;
         2'b01:   acc_o = ACC_READ;
         2'b10:   acc_o = ACC_WRITE;
         default: acc_o = ACC_CLASH;
      endcase
   end

endmodule

// File: rtl/cs_out_stage.sv
module cs_out_stage
   import cs_dec_pkg::*;
#(
   parameter int NUM_DEV = 2,
   parameter int DEV_AW  = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] hit_i,
   input  cs_access_e         acc_i,
   input  logic [DEV_AW-1:0]  local_i,
   output logic [NUM_DEV-1:0] cs_n_o,
   output logic               rd_dev_n_o,
   output logic               wr_dev_n_o,
   output logic [DEV_AW-1:0]  local_o,
   output logic               unmapped_o
);

   logic               any_hit;
   logic               live;
   logic [NUM_DEV-1:0] cs_n_d;
   logic               rd_d, wr_d, unm_d;

   always_comb begin
      any_hit = |hit_i;
      live    = acc_is_single(acc_i);
      cs_n_d  = live ? ~hit_i : '1;
      unm_d   = live && !any_hit;
      rd_d    = !((acc_i == ACC_READ)  && any_hit);
      wr_d    = !((acc_i == ACC_WRITE) && any_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_o     <= '1;
         rd_dev_n_o <= 1'b1;
         wr_dev_n_o <= 1'b1;
         local_o    <= '0;
         unmapped_o <= 1'b0;
      end else begin
         cs_n_o     <= cs_n_d;
         rd_dev_n_o <= rd_d;
         wr_dev_n_o <= wr_d;
         local_o    <= local_i;
         unmapped_o <= unm_d;
      end
   end

endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
   import cs_dec_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DEV_AW      = 18,
   parameter int NUM_DEV     = 2,
   parameter int BASE_SLOT   = 2,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               rd_n,
   input  logic               wr_n,
   output logic [NUM_DEV-1:0] cs_n,
   output logic               rd_dev_n,
   output logic               wr_dev_n,
   output logic [DEV_AW-1:0]  local_addr,
   output logic               unmapped
);

   localparam int SEL_W     = ADDR_W - DEV_AW;
   localparam int NUM_SLOTS = 1 << SEL_W;

   // Elaboration-time parameter checks
   if (DEV_AW < 1 || DEV_AW >= ADDR_W) begin : g_bad_aw
      $error("DEV_AW must lie between 1 and ADDR_W-1");
   end
   if (NUM_DEV < 1 || NUM_DEV > NUM_SLOTS) begin : g_bad_count
      $error("NUM_DEV must fit in the slot space");
   end
   if (FULL_DECODE && (BASE_SLOT < 0 || BASE_SLOT + NUM_DEV > NUM_SLOTS)) begin : g_bad_base
      $error("device window runs past the top of the map");
   end
   if (!FULL_DECODE && ((NUM_DEV & (NUM_DEV - 1)) != 0)) begin : g_bad_pow2
      $error("partial decoding needs a power-of-two device count");
   end

   logic [SEL_W-1:0]   slot;
   logic [NUM_DEV-1:0] hit_vec;
   cs_access_e         acc;

   assign slot = bus_addr[ADDR_W-1:DEV_AW];

   cs_slot_match #(
      .SEL_W      (SEL_W),
      .NUM_DEV    (NUM_DEV),
      .BASE_SLOT  (BASE_SLOT),
      .FULL_DECODE(FULL_DECODE)
   ) u_match (
      .slot_i(slot),
      .hit_o (hit_vec)
   );

   cs_access_qual u_qual (
      .rd_n_i(rd_n),
      .wr_n_i(wr_n),
      .acc_o (acc)
   );

   cs_out_stage #(
      .NUM_DEV(NUM_DEV),
      .DEV_AW (DEV_AW)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit_vec),
      .acc_i     (acc),
      .local_i   (bus_addr[DEV_AW-1:0]),
      .cs_n_o    (cs_n),
      .rd_dev_n_o(rd_dev_n),
      .wr_dev_n_o(wr_dev_n),
      .local_o   (local_addr),
      .unmapped_o(unmapped)
   );

endmodule

// File: rtl/memmap_cs_decoder_chk.sv
module memmap_cs_decoder_chk #(
   parameter int ADDR_W  = 20,
   parameter int DEV_AW  = 18,
   parameter int NUM_DEV = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               rd_n,
   input logic               wr_n,
   input logic [NUM_DEV-1:0] cs_n,
   input logic               rd_dev_n,
   input logic               wr_dev_n,
   input logic [DEV_AW-1:0]  local_addr,
   input logic               unmapped
);

   // Set one edge after reset release, so $past never reaches into reset
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r5_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   a_r3_hole_has_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (&cs_n));

   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(rd_n) && $past(wr_n)) |->
         ((&cs_n) && rd_dev_n && wr_dev_n && !unmapped));

   a_r7_clash_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(rd_n) && !$past(wr_n)) |->
         ((&cs_n) && rd_dev_n && wr_dev_n && !unmapped));

   a_r8_local_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (local_addr == $past(bus_addr[DEV_AW-1:0])));

   a_r9_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_dev_n |-> (!(&cs_n) && wr_dev_n));

   a_r9_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dev_n |-> (!(&cs_n) && rd_dev_n));

endmodule

bind memmap_cs_decoder memmap_cs_decoder_chk #(
   .ADDR_W (ADDR_W),
   .DEV_AW (DEV_AW),
   .NUM_DEV(NUM_DEV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .cs_n      (cs_n),
   .rd_dev_n  (rd_dev_n),
   .wr_dev_n  (wr_dev_n),
   .local_addr(local_addr),
   .unmapped  (unmapped)
);

// File: tb/memmap_cs_decoder_tb.sv
`timescale 1ns/1ps
module memmap_cs_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;

   // Main instance: four 256 KB slots, two devices at slots 2 and 3, full decode
   logic [1:0]   cs_n_m;
   logic         rdd_m, wrd_m, unm_m;
   logic [17:0]  loc_m;
   // Partial instance: one 512 KB device, upper bit ignored
   logic [0:0]   cs_n_p;
   logic         rdd_p, wrd_p, unm_p;
   logic [18:0]  loc_p;
   // Fine instance: 128 devices of 8 KB
   logic [127:0] cs_n_f;
   logic         rdd_f, wrd_f, unm_f;
   logic [12:0]  loc_f;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   memmap_cs_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n),
      .cs_n(cs_n_m), .rd_dev_n(rdd_m), .wr_dev_n(wrd_m),
      .local_addr(loc_m), .unmapped(unm_m));

   memmap_cs_decoder #(.DEV_AW(19), .NUM_DEV(1), .BASE_SLOT(1), .FULL_DECODE(1'b0)) u_dut_part (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n),
      .cs_n(cs_n_p), .rd_dev_n(rdd_p), .wr_dev_n(wrd_p),
      .local_addr(loc_p), .unmapped(unm_p));

   memmap_cs_decoder #(.DEV_AW(13), .NUM_DEV(128), .BASE_SLOT(0), .FULL_DECODE(1'b1)) u_dut_fine (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n),
      .cs_n(cs_n_f), .rd_dev_n(rdd_f), .wr_dev_n(wrd_f),
      .local_addr(loc_f), .unmapped(unm_f));

   // {addr[19:0], rd_n, wr_n, cs_n[1:0], unmapped} for the main instance
   localparam int NVEC = 11;
   localparam logic [24:0] VEC [NVEC] = '{
      {20'h80000, 1'b0, 1'b1, 2'b10, 1'b0},
      {20'hC0005, 1'b1, 1'b0, 2'b01, 1'b0},
      {20'h01234, 1'b0, 1'b1, 2'b11, 1'b1},
      {20'h4FFFF, 1'b1, 1'b0, 2'b11, 1'b1},
      {20'hBFFFF, 1'b0, 1'b1, 2'b10, 1'b0},
      {20'hFFFFF, 1'b0, 1'b1, 2'b01, 1'b0},
      {20'h80000, 1'b1, 1'b1, 2'b11, 1'b0},
      {20'hC0000, 1'b0, 1'b0, 2'b11, 1'b0},
      {20'h7FFFF, 1'b0, 1'b1, 2'b11, 1'b1},
      {20'hA0023, 1'b1, 1'b0, 2'b10, 1'b0},
      {20'h3FFFF, 1'b1, 1'b1, 2'b11, 1'b0}
   };

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected active-low enables from the requirement rules (R2, R3, R4, R6, R7)
   function automatic logic [127:0] exp_cs(input logic [19:0] a, input int aw, input int n,
                                           input int base, input bit full,
                                           input logic rn, input logic wn);
      logic [127:0] r = '0;
      int slot = int'(a >> aw);
      int idx  = -1;
      for (int i = 0; i < n; i++) r[i] = 1'b1;
      if (rn ^ wn) begin
         if (full) begin
            if (slot >= base && slot < base + n) idx = slot - base;
         end else begin
            idx = (slot - base) & (n - 1);
         end
         if (idx >= 0) r[idx] = 1'b0;
      end
      return r;
   endfunction

   // Drive after a falling edge, let one rising edge register it, sample at the next falling edge (R10)
   task automatic apply(input logic [19:0] a, input logic rn, input logic wn);
      bus_addr = a;
      rd_n     = rn;
      wr_n     = wn;
      @(negedge clk);
   endtask

   task automatic check_side(input logic [19:0] a, input logic rn, input logic wn);
      logic [127:0] ep, ef;
      logic         hp, hf;
      ep = exp_cs(a, 19, 1, 1, 1'b0, rn, wn);
      ef = exp_cs(a, 13, 128, 0, 1'b1, rn, wn);
      hp = (rn ^ wn);
      hf = (rn ^ wn);
      check("R4 partial enable", 128'(cs_n_p), ep);
      check("R4 partial unmapped", 128'(unm_p), 128'(1'b0));
      check("R8 partial local", 128'(loc_p), 128'(a[18:0]));
      check("R11 fine enable", cs_n_f, ef);
      check("R8 fine local", 128'(loc_f), 128'(a[12:0]));
      check("R9 partial read gate", 128'(rdd_p), 128'(!(hp && !rn)));
      check("R9 fine write gate", 128'(wrd_f), 128'(!(hf && !wn)));
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state while strobes request a mapped read
      bus_addr = 20'hC1234;
      rd_n     = 1'b0;
      wr_n     = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset cs_n", 128'(cs_n_m), 128'(2'b11));
      check("R1 reset unmapped", 128'(unm_m), 128'(0));
      check("R1 reset local", 128'(loc_m), 128'(0));
      check("R1 reset rd gate", 128'(rdd_m), 128'(1));
      check("R1 reset fine cs_n", cs_n_f, {128{1'b1}});
      rd_n  = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk over the main instance (R2, R3, R6, R7, R8, R9)
      for (int v = 0; v < NVEC; v++) begin
         logic [19:0] a;
         logic        rn, wn;
         a  = VEC[v][24:5];
         rn = VEC[v][4];
         wn = VEC[v][3];
         apply(a, rn, wn);
         check("R2/R3 main cs_n", 128'(cs_n_m), 128'(VEC[v][2:1]));
         check("R3 main unmapped", 128'(unm_m), 128'(VEC[v][0]));
         check("R8 main local", 128'(loc_m), 128'(a[17:0]));
         check("R9 main rd gate", 128'(rdd_m), 128'(!(!rn && wn && (VEC[v][2:1] != 2'b11))));
         check("R9 main wr gate", 128'(wrd_m), 128'(!(rn && !wn && (VEC[v][2:1] != 2'b11))));
         check("R5 main one enable", 128'($countones(~cs_n_m) <= 1), 128'(1));
         check_side(a, rn, wn);
      end

      // R4: both images of the half-size device reach the same location
      apply(20'hA0023, 1'b0, 1'b1);
      check("R4 alias high image cs", 128'(cs_n_p), 128'(1'b0));
      check("R4 alias high image local", 128'(loc_p), 128'(19'h20023));
      apply(20'h20023, 1'b0, 1'b1);
      check("R4 alias low image cs", 128'(cs_n_p), 128'(1'b0));
      check("R4 alias low image local", 128'(loc_p), 128'(19'h20023));

      // R11: A19..A13 select among 128 devices
      apply(20'h1E000, 1'b1, 1'b0);
      check("R11 fine slot 15", cs_n_f, ~(128'(1) << 15));
      apply(20'hFFFFF, 1'b0, 1'b1);
      check("R11 fine slot 127", cs_n_f, ~(128'(1) << 127));
      check("R11 fine no hole", 128'(unm_f), 128'(0));

      // R7: clash on the fine map leaves every enable off
      apply(20'h00000, 1'b0, 1'b0);
      check("R7 fine clash", cs_n_f, {128{1'b1}});
      check("R7 fine clash gates", 128'({rdd_f, wrd_f}), 128'(2'b11));

      // R10: outputs hold until the next rising edge
      apply(20'h80010, 1'b0, 1'b1);
      bus_addr = 20'hC0010;
      #3;
      check("R10 hold before edge", 128'(cs_n_m), 128'(2'b10));
      @(negedge clk);
      check("R10 update after edge", 128'(cs_n_m), 128'(2'b01));

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      #1;
      check("R1 async reset cs_n", 128'(cs_n_m), 128'(2'b11));
      check("R1 async reset rd gate", 128'(rdd_m), 128'(1));
      check("R1 async reset local", 128'(loc_m), 128'(0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule